// File: doc/BRIEF.md
# Complementary PWM Pair with Dead Time and Fault Shutdown

This block drives one complementary pair of gate signals for a half bridge. A free-running up-counter sweeps from a programmable start value to a modulus and then restarts. Two compare values place the rising and falling edge of the main output inside each period. The partner output is the inverse of the main output. A dead-time stage holds back every rising edge of either gate, so the two switches of the bridge are never on at the same time.

Four fault pins feed a glitch filter. Each pin has its own enable and its own active level. When a fault is recognised, a small state machine forces both gates to programmable safe levels at once and raises a sticky fault flag. The gates come back only at a period boundary. In manual recovery, software must first clear the flag. In automatic recovery, the fault input only has to go inactive.

The fault state machine has three states:
- RUN: gates driven by the PWM path.
- SAFE: gates forced to the safe levels.
- WAIT: fault gone, waiting for the period boundary.

Its transitions are:
- TRIP: RUN to SAFE, on a recognised fault.
- RELEASE: SAFE to WAIT. In manual mode this needs the flag cleared; in automatic mode it needs no recognised fault.
- RESUME: WAIT to RUN, on the counter wrap.
- RETRIP: WAIT to SAFE, on a new recognised fault.

Top module: `pwm_cdt_top`

## Requirements
- R1: While reset is held, both gate outputs and the fault flag are low.
- R2: The counter runs from `cnt_init` up to `cnt_mod` and then returns to `cnt_init`, so a period is `cnt_mod - cnt_init + 1` cycles. With zero dead time, the main gate is high for exactly the counts c with `cmp_lead <= c < cmp_trail`, and the partner gate is its exact complement.
- R3: The two gates are never high in the same cycle, unless both safe levels are programmed high.
- R4: Each rising edge of either gate is delayed by D system clocks, where D is `dt_count` times a scale set by `dt_scale`: 2'b00 gives 1, 2'b01 gives 4, and 2'b10 or 2'b11 give 16. Falling edges are not delayed, so each high pulse is shortened by D.
- R5: New compare values written during a period take effect only after the next counter wrap.
- R6: When `cmp_lead <= cnt_init` and `cmp_trail > cnt_mod`, the main gate stays high for the whole period and the partner stays low. No dead time appears, because there is no edge.
- R7: Fault pin i is active when `flt_en[i]` is 1 and the pin equals `flt_pol[i]` (1 means active high). A fault is recognised only after the pin has been active for 16 consecutive cycles. A pulse of 15 cycles or fewer is ignored, and so is any disabled pin.
- R8: The cycle after a fault is recognised, `gate_hi` equals `safe_hi`, `gate_lo` equals `safe_lo`, and `flt_flag` is set.
- R9: A one-cycle `flag_clr` clears `flt_flag` only when no recognised fault is present. Otherwise the flag stays set.
- R10: With `flt_auto` = 0, the gates stay at the safe levels until the flag has been cleared. With `flt_auto` = 1, they stay there until the fault is no longer recognised, and the flag stays set. In both modes, PWM drive returns on the first cycle after the next counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_init | input | CNT_W | Counter restart value |
| cnt_mod | input | CNT_W | Counter modulus (last count of a period) |
| cmp_lead | input | CNT_W | Count at which the main gate rises |
| cmp_trail | input | CNT_W | Count at which the main gate falls |
| dt_scale | input | 2 | Dead-time scale select |
| dt_count | input | DT_W | Dead-time count |
| flt_en | input | FLT_N | Per-pin fault enable |
| flt_pol | input | FLT_N | Per-pin active level |
| flt_auto | input | 1 | 1 selects automatic recovery |
| safe_hi | input | 1 | Forced level of the main gate |
| safe_lo | input | 1 | Forced level of the partner gate |
| flt_pin | input | FLT_N | Raw fault inputs |
| flag_clr | input | 1 | Request to clear the fault flag |
| gate_hi | output | 1 | Main gate |
| gate_lo | output | 1 | Partner gate |
| flt_flag | output | 1 | Sticky fault flag |

## Verification
The PWM path is tested with a centred window, an offset start value with a narrow window, and a full-period compare. These patterns separate errors in the start value, the modulus and the edge comparisons. High-time counts over whole periods are measured for every dead-time scale, including a dead time that nearly uses up the pulse. This separates the scale decoding from a wrong edge choice, such as delaying falls instead of rises. A compare rewrite just after the main gate falls shows whether the compare values are shadowed until the wrap. The fault tests use a 15-cycle pulse and a 16-cycle pulse, an active-low pin, a disabled pin, and a flag clear attempted while the fault is held. The phase of the first partner-gate rise after recovery, measured against the PWM phase recorded before the fault, shows whether recovery waits for the period boundary.

// File: rtl/pwm_cdt_pkg.sv
package pwm_cdt_pkg;

    typedef enum logic [1:0] {
        FS_RUN  = 2'd0,
        FS_SAFE = 2'd1,
        FS_WAIT = 2'd2
    } flt_state_e;

    localparam int unsigned DT_SHIFT_MID = 2;
    localparam int unsigned DT_SHIFT_TOP = 4;

endpackage

// File: rtl/pwm_cmp_gen.sv
module pwm_cmp_gen #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_init,
    input  logic [CNT_W-1:0] cnt_mod,
    input  logic [CNT_W-1:0] cmp_lead,
    input  logic [CNT_W-1:0] cmp_trail,
    output logic             wrap,
    output logic             raw_hi,
    output logic             raw_lo
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lead_s;
    logic [CNT_W-1:0] trail_s;
    logic             in_win;

    assign wrap   = (cnt_q >= cnt_mod);
    assign in_win = (cnt_q >= lead_s) && (cnt_q < trail_s);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            lead_s  <= '0;
            trail_s <= '0;
        end else if (wrap) begin
            cnt_q   <= cnt_init;
            lead_s  <= cmp_lead;
            trail_s <= cmp_trail;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_hi <= 1'b0;
            raw_lo <= 1'b0;
        end else begin
            raw_hi <= in_win;
            raw_lo <= !in_win;
        end
    end

endmodule

// File: rtl/pwm_dt_edge.sv
module pwm_dt_edge
    import pwm_cdt_pkg::*;
#(
    parameter int unsigned DT_W   = 6,
    parameter int unsigned SPAN_W = DT_W + 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw,
    input  logic [1:0]      dt_scale,
    input  logic [DT_W-1:0] dt_count,
    output logic            drv
);

    logic [SPAN_W-1:0] base;
    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] hi_q;

    assign base = {{(SPAN_W-DT_W){1'b0}}, dt_count};

    always_comb begin
        case (dt_scale)
            2'b00:   span = base;
            2'b01:   span = base << DT_SHIFT_MID;
            default: span = base << DT_SHIFT_TOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            drv  <= 1'b0;
        end else begin
            if (!raw)
                hi_q <= '0;
            else if (hi_q != '1)
                hi_q <= hi_q + 1'b1;
            drv <= raw && (hi_q >= span);
        end
    end

endmodule

// File: rtl/pwm_flt_filter.sv
module pwm_flt_filter #(
    parameter int unsigned FLT_N      = 4,
    parameter int unsigned GLITCH_MAX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLT_N-1:0] flt_pin,
    input  logic [FLT_N-1:0] flt_en,
    input  logic [FLT_N-1:0] flt_pol,
    output logic             any_flt
);

    localparam int unsigned RUN_W = $clog2(GLITCH_MAX + 2);
    localparam logic [RUN_W-1:0] ACCEPT = RUN_W'(GLITCH_MAX + 1);

    logic [FLT_N-1:0] hit;

    for (genvar gi = 0; gi < FLT_N; gi++) begin : g_pin
        logic             act;
        logic [RUN_W-1:0] run_q;

        assign act     = flt_en[gi] && (flt_pin[gi] == flt_pol[gi]);
        assign hit[gi] = (run_q == ACCEPT);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                run_q <= '0;
            else if (!act)
                run_q <= '0;
            else if (run_q != ACCEPT)
                run_q <= run_q + 1'b1;
        end
    end

    assign any_flt = |hit;

endmodule

// File: rtl/pwm_flt_fsm.sv
module pwm_flt_fsm
    import pwm_cdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_flt,
    input  logic wrap,
    input  logic flt_auto,
    input  logic flag_clr,
    output logic force_safe,
    output logic flt_flag
);

    flt_state_e state_q, state_d;
    logic       released;

    assign released = !any_flt && (flt_auto || !flt_flag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= FS_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_RUN:  if (any_flt)  state_d = FS_SAFE;
            FS_SAFE: if (released) state_d = FS_WAIT;
            FS_WAIT: begin
                if (any_flt)   state_d = FS_SAFE;
                else if (wrap) state_d = FS_RUN;
            end
            default: state_d = FS_RUN;
        endcase
    end

    always_comb begin
        force_safe = (state_q != FS_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flt_flag <= 1'b0;
        else if (any_flt)
            flt_flag <= 1'b1;
        else if (flag_clr)
            flt_flag <= 1'b0;
    end

endmodule

// File: rtl/pwm_cdt_top.sv
module pwm_cdt_top #(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned DT_W       = 6,
    parameter int unsigned FLT_N      = 4,
    parameter int unsigned GLITCH_MAX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_init,
    input  logic [CNT_W-1:0] cnt_mod,
    input  logic [CNT_W-1:0] cmp_lead,
    input  logic [CNT_W-1:0] cmp_trail,
    input  logic [1:0]       dt_scale,
    input  logic [DT_W-1:0]  dt_count,
    input  logic [FLT_N-1:0] flt_en,
    input  logic [FLT_N-1:0] flt_pol,
    input  logic             flt_auto,
    input  logic             safe_hi,
    input  logic             safe_lo,
    input  logic [FLT_N-1:0] flt_pin,
    input  logic             flag_clr,
    output logic             gate_hi,
    output logic             gate_lo,
    output logic             flt_flag
);

    localparam int unsigned SPAN_W = DT_W + 5;

    logic       wrap;
    logic       raw_hi;
    logic       raw_lo;
    logic       any_flt;
    logic       force_safe;
    logic [1:0] raw_pair;
    logic [1:0] drv_pair;

    pwm_cmp_gen #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_init (cnt_init),
        .cnt_mod  (cnt_mod),
        .cmp_lead (cmp_lead),
        .cmp_trail(cmp_trail),
        .wrap     (wrap),
        .raw_hi   (raw_hi),
        .raw_lo   (raw_lo)
    );

    assign raw_pair = {raw_lo, raw_hi};

    for (genvar gk = 0; gk < 2; gk++) begin : g_dt
        pwm_dt_edge #(.DT_W(DT_W), .SPAN_W(SPAN_W)) u_dt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw     (raw_pair[gk]),
            .dt_scale(dt_scale),
            .dt_count(dt_count),
            .drv     (drv_pair[gk])
        );
    end

    pwm_flt_filter #(.FLT_N(FLT_N), .GLITCH_MAX(GLITCH_MAX)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .flt_pin(flt_pin),
        .flt_en (flt_en),
        .flt_pol(flt_pol),
        .any_flt(any_flt)
    );

    pwm_flt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_flt   (any_flt),
        .wrap      (wrap),
        .flt_auto  (flt_auto),
        .flag_clr  (flag_clr),
        .force_safe(force_safe),
        .flt_flag  (flt_flag)
    );

    assign gate_hi = force_safe ? safe_hi : drv_pair[0];
    assign gate_lo = force_safe ? safe_lo : drv_pair[1];

endmodule

// File: rtl/pwm_cdt_chk.sv
module pwm_cdt_chk (
    input logic clk,
    input logic rst_n,
    input logic gate_hi,
    input logic gate_lo,
    input logic flt_flag,
    input logic safe_hi,
    input logic safe_lo,
    input logic flag_clr,
    input logic raw_hi,
    input logic any_flt,
    input logic force_safe,
    input logic wrap
);

    a_r3_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(safe_hi && safe_lo) |-> !(gate_hi && gate_lo));

    a_r4_rise_after_raw: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_hi) && !force_safe) |-> $past(raw_hi));

    a_r4_fall_undelayed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw_hi) |=> (!gate_hi || force_safe));

    a_r8_trip_forces: assert property (@(posedge clk) disable iff (!rst_n)
        any_flt |=> (gate_hi == safe_hi && gate_lo == safe_lo && flt_flag));

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_flag && (any_flt || !flag_clr)) |=> flt_flag);

    a_r10_resume_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(force_safe) |-> $past(wrap));

endmodule

bind pwm_cdt_top pwm_cdt_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo),
    .flt_flag  (flt_flag),
    .safe_hi   (safe_hi),
    .safe_lo   (safe_lo),
    .flag_clr  (flag_clr),
    .raw_hi    (raw_hi),
    .any_flt   (any_flt),
    .force_safe(force_safe),
    .wrap      (wrap)
);

// File: tb/pwm_cdt_top_tb_top.sv
module pwm_cdt_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_init = '0;
    logic [15:0] cnt_mod = 16'd19;
    logic [15:0] cmp_lead = '0;
    logic [15:0] cmp_trail = '0;
    logic [1:0]  dt_scale = '0;
    logic [5:0]  dt_count = '0;
    logic [3:0]  flt_en = 4'b0111;
    logic [3:0]  flt_pol = 4'b1011;
    logic        flt_auto = 1'b0;
    logic        safe_hi = 1'b0;
    logic        safe_lo = 1'b0;
    logic [3:0]  flt_pin = 4'b0100;
    logic        flag_clr = 1'b0;
    logic        gate_hi;
    logic        gate_lo;
    logic        flt_flag;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4ns clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_cdt_top dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_init(cnt_init), .cnt_mod(cnt_mod),
        .cmp_lead(cmp_lead), .cmp_trail(cmp_trail), .dt_scale(dt_scale),
        .dt_count(dt_count), .flt_en(flt_en), .flt_pol(flt_pol),
        .flt_auto(flt_auto), .safe_hi(safe_hi), .safe_lo(safe_lo),
        .flt_pin(flt_pin), .flag_clr(flag_clr), .gate_hi(gate_hi),
        .gate_lo(gate_lo), .flt_flag(flt_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int n, output int nh, output int nl, output int nb);
        nh = 0; nl = 0; nb = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gate_hi) nh++;
            if (gate_lo) nl++;
            if (gate_hi && gate_lo) nb++;
        end
    endtask

    task automatic set_pwm(input int ini, input int md, input int ld, input int tr,
                           input int sc, input int dc);
        cnt_init  = 16'(ini);
        cnt_mod   = 16'(md);
        cmp_lead  = 16'(ld);
        cmp_trail = 16'(tr);
        dt_scale  = 2'(sc);
        dt_count  = 6'(dc);
    endtask

    task automatic find_rise_hi(output int r);
        logic prev;
        prev = gate_hi;
        r = -1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (gate_hi && !prev) begin r = cyc; break; end
            prev = gate_hi;
        end
    endtask

    task automatic find_lo_high(output int s);
        s = -1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (gate_lo) begin s = cyc; break; end
        end
    endtask

    task automatic pulse_clr;
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset;
        wait_n(3);
        check(!gate_hi && !gate_lo, "R1 gates low in reset", {gate_hi, gate_lo}, 0);
        check(!flt_flag, "R1 flag low in reset", flt_flag, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_basic;
        int h, l, b;
        set_pwm(0, 19, 5, 15, 0, 0);
        wait_n(80);
        measure(100, h, l, b);
        check(h == 50, "R2 centred window high time", h, 50);
        check(l == 50, "R2 complement high time", l, 50);
        check(b == 0, "R3 overlap count", b, 0);
        set_pwm(4, 23, 8, 12, 0, 0);
        wait_n(80);
        measure(100, h, l, b);
        check(h == 20, "R2 offset start narrow window", h, 20);
        check(l == 80, "R2 offset start complement", l, 80);
    endtask

    task automatic t_deadtime;
        int h, l, b;
        set_pwm(0, 19, 5, 15, 0, 3);
        wait_n(80);
        measure(100, h, l, b);
        check(h == 35 && l == 35, "R4 scale 1 count 3", h, 35);
        check(b == 0, "R3 overlap with dead time", b, 0);
        set_pwm(0, 19, 5, 15, 1, 1);
        wait_n(80);
        measure(100, h, l, b);
        check(h == 30 && l == 30, "R4 scale 4 count 1", l, 30);
        set_pwm(0, 99, 10, 60, 2, 1);
        wait_n(300);
        measure(300, h, l, b);
        check(h == 102 && l == 102, "R4 scale 16 count 1", h, 102);
        set_pwm(0, 99, 10, 60, 3, 3);
        wait_n(300);
        measure(300, h, l, b);
        check(h == 6 && l == 6, "R4 scale code 3 near-full dead time", h, 6);
    endtask

    task automatic t_shadow;
        int h, l, b, early;
        logic prev;
        set_pwm(0, 99, 10, 60, 0, 0);
        wait_n(300);
        prev = gate_hi;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!gate_hi && prev) break;
            prev = gate_hi;
        end
        cmp_lead  = 16'd0;
        cmp_trail = 16'd90;
        early = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (gate_hi) early++;
        end
        check(early == 0, "R5 new compare held until wrap", early, 0);
        wait_n(300);
        measure(300, h, l, b);
        check(h == 270, "R5 new compare after wrap", h, 270);
    endtask

    task automatic t_full_on;
        int h, l, b;
        set_pwm(0, 99, 0, 100, 2, 1);
        wait_n(300);
        measure(300, h, l, b);
        check(h == 300, "R6 main high all period", h, 300);
        check(l == 0, "R6 partner low all period", l, 0);
    endtask

    task automatic t_glitch;
        int h, l, b;
        set_pwm(0, 99, 10, 60, 0, 0);
        wait_n(300);
        flt_pin[0] = 1'b1;
        wait_n(15);
        flt_pin[0] = 1'b0;
        wait_n(3);
        check(!flt_flag, "R7 15-cycle glitch ignored", flt_flag, 0);
        measure(300, h, l, b);
        check(h == 150 && l == 150, "R7 gates unaffected by glitch", h, 150);
        flt_pin[3] = 1'b1;
        wait_n(40);
        flt_pin[3] = 1'b0;
        check(!flt_flag, "R7 disabled pin ignored", flt_flag, 0);
        measure(300, h, l, b);
        check(h == 150 && l == 150, "R7 gates unaffected by disabled pin", l, 150);
    endtask

    task automatic t_manual;
        int r, s, bad;
        flt_auto = 1'b0; safe_hi = 1'b0; safe_lo = 1'b0;
        find_rise_hi(r);
        flt_pin[0] = 1'b1;
        wait_n(16);
        flt_pin[0] = 1'b0;
        wait_n(2);
        check(flt_flag, "R7 16-cycle fault recognised", flt_flag, 1);
        check(!gate_hi && !gate_lo, "R8 forced to safe 0/0", {gate_hi, gate_lo}, 0);
        flt_pin[1] = 1'b1;
        wait_n(30);
        pulse_clr();
        wait_n(2);
        check(flt_flag, "R9 clear refused while fault present", flt_flag, 1);
        flt_pin[1] = 1'b0;
        bad = 0;
        for (int i = 0; i < 250; i++) begin
            @(negedge clk);
            if (gate_hi || gate_lo) bad++;
        end
        check(bad == 0, "R10 manual holds safe until flag clear", bad, 0);
        pulse_clr();
        check(!flt_flag, "R9 flag cleared", flt_flag, 0);
        find_lo_high(s);
        check(s > r && (s - r) % 100 == 88, "R10 manual resume at period start", (s - r) % 100, 88);
    endtask

    task automatic t_auto;
        int r, s;
        flt_auto = 1'b1; safe_hi = 1'b1; safe_lo = 1'b0;
        wait_n(300);
        find_rise_hi(r);
        flt_pin[2] = 1'b0;
        wait_n(40);
        check(flt_flag, "R7 active-low pin recognised", flt_flag, 1);
        check(gate_hi && !gate_lo, "R8 forced to safe 1/0", {gate_hi, gate_lo}, 2);
        flt_pin[2] = 1'b1;
        find_lo_high(s);
        check(s > r && (s - r) % 100 == 88, "R10 auto resume at period start", (s - r) % 100, 88);
        check(flt_flag, "R10 auto keeps flag", flt_flag, 1);
        pulse_clr();
        check(!flt_flag, "R9 flag cleared after auto", flt_flag, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_deadtime();
        t_shadow();
        t_full_on();
        t_glitch();
        t_manual();
        t_auto();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule